// File: doc/BRIEF.md
# Event counter group with set/clear bitmaps

This block is a bank of event counters. Each counter counts its own event pulse once it has been armed. Software programs the bank over a simple register bus. Each cycle it may issue one write strobe or one read strobe, with a 12-bit byte address and 64-bit data. Reads return their data one cycle later.

Each counter has an enable, an interrupt enable and an overflow status. These are kept as bitmaps indexed by counter number. Every bitmap has one address where written ones set bits and another where written ones clear bits. Written zeros never change state. A counter can be preloaded by writing it, and it flags overflow when it wraps past all-ones. The level interrupt output reports flagged counters whose interrupts are unmasked.

Each counter also has an event-type register. The type value 0xFFFF freezes that counter whatever the enables say. This gives software a way to stop a counter that does not rely on the global enable. A per-counter 32-bit stream-pattern register is held for the filtering logic outside the block. A read-only capability word and a 128-bit supported-event map describe the bank's build.

Top module: `evcnt_group`

## Requirements
- R1: After reset, every counter, the enable, interrupt-enable and overflow bitmaps, both global enables and `irq` are zero.
- R2: Counter i adds exactly 1 in the cycle after a clock edge that sees `evt[i]`=1, the global count enable (0xE04 bit 0) set and enable bit i set. Otherwise it holds its value.
- R3: Each bitmap has its own pair of addresses: enable set 0xC00 / clear 0xC20, interrupt-enable set 0xC40 / clear 0xC60, overflow set 0xCC0 / clear 0xC80. A 1 in bit i of the written data sets or clears bit i, and a 0 leaves it alone. Reading either address of a pair returns the bitmap.
- R4: Counter i is read and written at byte address i*4 when CNT_W ≤ 32, and at i*8 otherwise. A write preloads the counter, and it takes precedence over an event in the same cycle.
- R5: A counter that counts from all-ones wraps to 0 and sets its overflow bit. An overflow that coincides with a software clear of the same bit leaves the bit set.
- R6: A counter whose event-type register holds 0xFFFF does not count, even when it is enabled. Any other type value lets it count.
- R7: `irq` is high while the global interrupt enable (0xE50 bit 0) is set and at least one counter has both its overflow bit and its interrupt-enable bit set. It follows register state in the same cycle.
- R8: Address 0xE00 reads as follows: NUM_CNT-1 in bits 5:0, CNT_W-1 in bits 13:8, bit 23 = GLOBAL_FILT, and every other bit 0.
- R9: Addresses 0xE20 and 0xE28 return the low and high halves of the SUPP_EVT map.
- R10: `rdata` takes the read result on the edge that samples `rd_en`. Unimplemented bits read 0, and unmapped addresses read 0.
- R11: The event type at 0x400+4i keeps bits 15:0 of the written data. The stream pattern at 0xA00+4i keeps bits 31:0. Both read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, updated the cycle after `rd_en` |
| evt | input | NUM_CNT | Per-counter event pulses |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the block with four 8-bit counters, global filter type set and a supported-event map of 0x5 high and 0xFF low. The short width lets a preload of 0xFF reach a wrap in a single pulse, so overflow, set-versus-clear priority and the interrupt path are exercised within a few cycles. It also selects the 4-byte counter stride and makes the high bits of wide writes visible as truncated. With four counters, writes of all ones into the bitmaps show which bits are not implemented.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam logic [11:0] A_CNT_BASE = 12'h000;
  localparam logic [11:0] A_ETYPE    = 12'h400;
  localparam logic [11:0] A_PATT     = 12'hA00;
  localparam logic [11:0] A_EN_SET   = 12'hC00;
  localparam logic [11:0] A_EN_CLR   = 12'hC20;
  localparam logic [11:0] A_IE_SET   = 12'hC40;
  localparam logic [11:0] A_IE_CLR   = 12'hC60;
  localparam logic [11:0] A_OV_CLR   = 12'hC80;
  localparam logic [11:0] A_OV_SET   = 12'hCC0;
  localparam logic [11:0] A_CFG      = 12'hE00;
  localparam logic [11:0] A_CTL      = 12'hE04;
  localparam logic [11:0] A_SUP_LO   = 12'hE20;
  localparam logic [11:0] A_SUP_HI   = 12'hE28;
  localparam logic [11:0] A_IRQCTL   = 12'hE50;

  localparam logic [15:0] HALT_TYPE  = 16'hFFFF;

  function automatic logic [11:0] slot_addr(logic [11:0] base, int idx, int stride);
    return base + 12'(idx * stride);
  endfunction

  function automatic logic [63:0] cfg_word(int n, int w, logic gf);
    logic [63:0] c;
    c        = '0;
    c[5:0]   = 6'(n - 1);
    c[13:8]  = 6'(w - 1);
    c[23]    = gf;
    return c;
  endfunction
endpackage

// File: rtl/evcnt_slot.sv
module evcnt_slot
  import evcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             type_we,
  input  logic [15:0]      type_wdata,
  input  logic             patt_we,
  input  logic [31:0]      patt_wdata,
  output logic [CNT_W-1:0] value,
  output logic [15:0]      etype,
  output logic [31:0]      patt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic live;
  assign live = inc_req && (etype != HALT_TYPE);
  assign wrap = live && !cnt_we && (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      etype <= '0;
      patt  <= '0;
    end else begin
      if (cnt_we)    value <= cnt_wdata;
      else if (live) value <= value + ONE;
      if (type_we)   etype <= type_wdata;
      if (patt_we)   patt  <= patt_wdata;
    end
  end

  // R2
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !cnt_we) |=> (value == CNT_W'($past(value) + ONE)));
  // R4
  a_r4_preload: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (value == $past(cnt_wdata)));
  // R6
  a_r6_halted: assert property (@(posedge clk) disable iff (!rst_n)
    ((etype == HALT_TYPE) && !cnt_we) |=> $stable(value));
  // R5
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (value == '0));
endmodule

// File: rtl/evcnt_bitmap.sv
module evcnt_bitmap #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] wmask,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] bits
);
  logic [N-1:0] nxt;

  always_comb begin
    nxt = bits;
    if (clr_we) nxt = nxt & ~wmask;
    if (set_we) nxt = nxt | wmask;
    nxt = nxt | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= nxt;
  end

  // R5
  a_r5_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((bits & $past(hw_set)) == $past(hw_set)));
  // R3
  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((bits & $past(wmask)) == $past(wmask)));
  // R3
  a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((bits & $past(wmask) & ~$past(hw_set)) == '0));
  // R3
  a_r3_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we || clr_we) |=>
      (((bits ^ $past(bits)) & ~$past(wmask) & ~$past(hw_set)) == '0));
endmodule

// File: rtl/evcnt_group.sv
module evcnt_group
  import evcnt_pkg::*;
#(
  parameter int           NUM_CNT     = 8,
  parameter int           CNT_W       = 32,
  parameter logic         GLOBAL_FILT = 1'b0,
  parameter logic [127:0] SUPP_EVT    = 128'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [11:0]        addr,
  input  logic [63:0]        wdata,
  output logic [63:0]        rdata,
  input  logic [NUM_CNT-1:0] evt,
  output logic               irq
);
  localparam int          STRIDE   = (CNT_W > 32) ? 8 : 4;
  localparam logic [63:0] CFG_WORD = cfg_word(NUM_CNT, CNT_W, GLOBAL_FILT);

  logic               ctl_en, irq_on;
  logic [NUM_CNT-1:0] cnt_en, int_en, ovs;
  logic [NUM_CNT-1:0] wrap, inc_req, cnt_we, type_we, patt_we;
  logic [CNT_W-1:0]   cnt_val  [NUM_CNT];
  logic [15:0]        type_val [NUM_CNT];
  logic [31:0]        patt_val [NUM_CNT];
  logic [63:0]        rd_next;
  logic               unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      irq_on <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_CTL)    ctl_en <= wdata[0];
      if (addr == A_IRQCTL) irq_on <= wdata[0];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
    assign cnt_we[i]  = wr_en && (addr == slot_addr(A_CNT_BASE, i, STRIDE));
    assign type_we[i] = wr_en && (addr == slot_addr(A_ETYPE, i, 4));
    assign patt_we[i] = wr_en && (addr == slot_addr(A_PATT, i, 4));
    assign inc_req[i] = ctl_en && cnt_en[i] && evt[i];

    evcnt_slot #(.CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_req   (inc_req[i]),
      .cnt_we    (cnt_we[i]),
      .cnt_wdata (wdata[CNT_W-1:0]),
      .type_we   (type_we[i]),
      .type_wdata(wdata[15:0]),
      .patt_we   (patt_we[i]),
      .patt_wdata(wdata[31:0]),
      .value     (cnt_val[i]),
      .etype     (type_val[i]),
      .patt      (patt_val[i]),
      .wrap      (wrap[i])
    );
  end

  evcnt_bitmap #(.N(NUM_CNT)) u_en (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_en && addr == A_EN_SET), .clr_we(wr_en && addr == A_EN_CLR),
    .wmask(wdata[NUM_CNT-1:0]), .hw_set('0), .bits(cnt_en)
  );

  evcnt_bitmap #(.N(NUM_CNT)) u_ie (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_en && addr == A_IE_SET), .clr_we(wr_en && addr == A_IE_CLR),
    .wmask(wdata[NUM_CNT-1:0]), .hw_set('0), .bits(int_en)
  );

  evcnt_bitmap #(.N(NUM_CNT)) u_ovs (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_en && addr == A_OV_SET), .clr_we(wr_en && addr == A_OV_CLR),
    .wmask(wdata[NUM_CNT-1:0]), .hw_set(wrap), .bits(ovs)
  );

  assign irq = irq_on && ((ovs & int_en) != '0);

  always_comb begin
    rd_next = '0;
    case (addr)
      A_EN_SET, A_EN_CLR: rd_next = 64'(cnt_en);
      A_IE_SET, A_IE_CLR: rd_next = 64'(int_en);
      A_OV_SET, A_OV_CLR: rd_next = 64'(ovs);
      A_CFG:              rd_next = CFG_WORD;
      A_CTL:              rd_next = {63'b0, ctl_en};
      A_IRQCTL:           rd_next = {63'b0, irq_on};
      A_SUP_LO:           rd_next = SUPP_EVT[63:0];
      A_SUP_HI:           rd_next = SUPP_EVT[127:64];
      default:            rd_next = '0;
    endcase
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr == slot_addr(A_CNT_BASE, i, STRIDE)) rd_next = 64'(cnt_val[i]);
      if (addr == slot_addr(A_ETYPE, i, 4))         rd_next = 64'(type_val[i]);
      if (addr == slot_addr(A_PATT, i, 4))          rd_next = 64'(patt_val[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  // R7
  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_IRQCTL) && !wdata[0]) |=> !irq);
  // R2
  a_r2_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> (inc_req == '0));
endmodule

// File: tb/sim_evcnt_group.sv
`timescale 1ns/1ps
module sim_evcnt_group;
  localparam int NC = 4;
  localparam int CW = 8;

  typedef struct packed {
    logic        is_rd;
    logic [11:0] a;
    logic [63:0] d;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{1'b1, 12'hE00, 64'h800703, 8'd8},            // R8
    '{1'b1, 12'hE20, 64'hFF, 8'd9},                // R9
    '{1'b1, 12'hE28, 64'h5, 8'd9},                 // R9
    '{1'b0, 12'hC00, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3},
    '{1'b1, 12'hC00, 64'hF, 8'd10},                // R10 unimplemented bits
    '{1'b0, 12'hC20, 64'h5, 8'd3},
    '{1'b1, 12'hC20, 64'hA, 8'd3},                 // R3 read via clear address
    '{1'b0, 12'hC20, 64'h0, 8'd3},
    '{1'b1, 12'hC00, 64'hA, 8'd3},                 // R3 zeros ignored
    '{1'b0, 12'h004, 64'hFFFF_FFFF_FFFF_FF12, 8'd4},
    '{1'b1, 12'h004, 64'h12, 8'd4},                // R4 preload, truncated
    '{1'b0, 12'h404, 64'h0001_ABCD, 8'd11},
    '{1'b1, 12'h404, 64'hABCD, 8'd11},             // R11
    '{1'b0, 12'hA04, 64'h1234_5678_9ABC_DEF0, 8'd11},
    '{1'b1, 12'hA04, 64'h9ABC_DEF0, 8'd11},        // R11
    '{1'b1, 12'h100, 64'h0, 8'd10},                // R10 unmapped
    '{1'b0, 12'hC20, 64'hF, 8'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic [NC-1:0] evt = '0;
  logic          irq;
  int            tests = 0, fails = 0;
  bit            done = 1'b0;
  logic [63:0]   rv;

  always #10 clk = ~clk;

  evcnt_group #(.NUM_CNT(NC), .CNT_W(CW), .GLOBAL_FILT(1'b1),
                .SUPP_EVT({64'h5, 64'hFF})) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt(evt), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [NC-1:0] p);
    @(negedge clk);
    evt = p;
    @(posedge clk);
    @(negedge clk);
    evt = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {63'b0, irq}, 64'h0);
    rd(12'h000, rv); check("R1 counter0", rv, 64'h0);
    rd(12'hC00, rv); check("R1 enable map", rv, 64'h0);
    rd(12'hC40, rv); check("R1 irq enable map", rv, 64'h0);
    rd(12'hCC0, rv); check("R1 overflow map", rv, 64'h0);
    rd(12'hE04, rv); check("R1 global enable", rv, 64'h0);

    for (int k = 0; k < NV; k++) begin
      if (VT[k].is_rd) begin
        rd(VT[k].a, rv);
        check($sformatf("R%0d table entry %0d", VT[k].rq, k), rv, VT[k].d);
      end else begin
        wr(VT[k].a, VT[k].d);
      end
    end

    // R2 counting gated by global and per-counter enables
    wr(12'hE04, 64'h1);
    wr(12'hC00, 64'h3);
    for (int n = 0; n < 3; n++) pulse(4'b0111);
    rd(12'h000, rv); check("R2 counter0 counted", rv, 64'h3);
    rd(12'h004, rv); check("R2 counter1 counted", rv, 64'h15);
    rd(12'h008, rv); check("R2 counter2 disabled", rv, 64'h0);
    wr(12'hE04, 64'h0);
    pulse(4'b0001);
    rd(12'h000, rv); check("R2 global disable holds", rv, 64'h3);
    wr(12'hE04, 64'h1);

    // R4 preload beats a same-cycle event
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h004; wdata = 64'h40; evt = 4'b0010;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    rd(12'h004, rv); check("R4 preload over event", rv, 64'h40);

    // R5 wrap sets overflow
    wr(12'h000, 64'hFF);
    pulse(4'b0001);
    rd(12'h000, rv); check("R5 wrapped to zero", rv, 64'h0);
    rd(12'hCC0, rv); check("R5 overflow flagged", rv, 64'h1);
    wr(12'hC80, 64'h1);
    rd(12'hC80, rv); check("R3 overflow cleared", rv, 64'h0);
    // R5 overflow against same-cycle software clear
    wr(12'h000, 64'hFF);
    @(negedge clk);
    wr_en = 1'b1; addr = 12'hC80; wdata = 64'h1; evt = 4'b0001;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    rd(12'hCC0, rv); check("R5 set wins over clear", rv, 64'h1);

    // R7 interrupt gating
    check("R7 masked", {63'b0, irq}, 64'h0);
    wr(12'hC40, 64'h1);
    check("R7 global irq off", {63'b0, irq}, 64'h0);
    wr(12'hE50, 64'h1);
    check("R7 raised", {63'b0, irq}, 64'h1);
    wr(12'hC60, 64'h1);
    check("R7 irq enable cleared", {63'b0, irq}, 64'h0);
    wr(12'hC40, 64'h1);
    check("R7 re-enabled", {63'b0, irq}, 64'h1);
    wr(12'hC80, 64'h1);
    check("R7 status cleared", {63'b0, irq}, 64'h0);
    wr(12'hCC0, 64'h1);
    check("R3 R7 software set", {63'b0, irq}, 64'h1);
    wr(12'hE50, 64'h0);
    check("R7 global irq cleared", {63'b0, irq}, 64'h0);

    // R6 halting event type
    wr(12'hC00, 64'h4);
    wr(12'h408, 64'hFFFF);
    pulse(4'b0100);
    pulse(4'b0100);
    rd(12'h008, rv); check("R6 halted counter", rv, 64'h0);
    wr(12'h408, 64'h1);
    pulse(4'b0100);
    rd(12'h008, rv); check("R6 resumed counter", rv, 64'h1);

    finish_run();
  end
endmodule